// File: doc/BRIEF.md
# Split/Chained Capture Timer

This block is a 16-bit timer/counter built from two 8-bit halves that either run on their own or join into one wide counter. A shared programmable prescaler turns cycles with `tick_en` high into advance steps. An external event input gives a second step source. Each half has a match register. When a half reaches its match value, it raises a one-cycle interrupt flag and reloads to zero on its next advance. Two capture trigger inputs copy the live count into the capture outputs without disturbing the count.

The 2-bit `mode_sel` input sets how the halves are used:

| Value | Mode | Low half | High half | Capture |
|---|---|---|---|---|
| 0 | Split timers | Prescaled timer | Prescaled timer | 8-bit per half |
| 1 | Timer plus event counter | Prescaled timer | Counts events | 8-bit per half |
| 2 | Wide timer | One 16-bit prescaled timer | (joined) | 16-bit |
| 3 | Wide event counter | One 16-bit event counter | (joined) | 16-bit |

Each of the three external inputs passes through a two-flop synchronizer and then a two-state edge machine:
- **ARMED** waits for a synchronized high. On that high it emits a one-cycle step and moves to **SPENT** (transition ARMED→SPENT).
- **SPENT** waits for a synchronized low and then returns to **ARMED** (transition SPENT→ARMED).

Top module: `dct_capture_timer`

## Requirements
- R1: After reset, both capture outputs and both interrupt flags are 0 and both counters are 0. The prescale register resets to 0 and both match registers reset to all ones, so mode 0 with `tick_en` held high gives an `irq_lo` pulse once every 256 cycles.
- R2: With prescale value P, the prescaler produces one advance step per P+1 cycles in which `tick_en` is high. Cycles with `tick_en` low are not counted.
- R3: In mode 0, each half counts prescaler steps and compares against its own match value M. An advance that makes the count equal M raises that half's flag (`irq_lo` or `irq_hi`) for exactly one cycle. The next advance reloads the count to 0, so the flag repeats every (P+1)(M+1) enabled cycles, independently for each half.
- R4: In mode 1, the low half counts prescaler steps and the high half counts accepted events, each with its own 8-bit match value and flag.
- R5: In mode 2, the halves form one 16-bit timer clocked by prescaler steps. The wide match value is {match high, match low}, and `irq_hi` pulses once every (P+1)(M16+1) enabled cycles.
- R6: In mode 3, the halves form one 16-bit counter of accepted events, matched against {match high, match low}, with `irq_hi` as the flag.
- R7: In modes 2 and 3, `irq_lo` stays low.
- R8: Each rising edge on `evt_in` gives exactly one advance, however long the input then stays high. A pulse of at least one cycle high and one cycle low is accepted.
- R9: In modes 0 and 1, a rising edge on `cap_lo_in` copies the low count into `cap_lo`, and a rising edge on `cap_hi_in` copies the high count into `cap_hi`. Neither capture changes the count.
- R10: In modes 2 and 3, a rising edge on either trigger copies the full 16-bit count into {`cap_hi`, `cap_lo`}.
- R11: A write with `wr_en` high stores `wr_data` in the register chosen by `wr_sel`: 0 = prescale, 1 = low match, 2 = high match. `wr_sel` = 3 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Per-cycle enable counted by the prescaler |
| evt_in | input | 1 | External event input (asynchronous) |
| cap_lo_in | input | 1 | Low-half capture trigger (asynchronous) |
| cap_hi_in | input | 1 | High-half capture trigger (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| mode_sel | input | 2 | Operating mode 0..3 |
| irq_lo | output | 1 | Low-half match flag, one-cycle pulse |
| irq_hi | output | 1 | High-half or 16-bit match flag, one-cycle pulse |
| cap_lo | output | 8 | Low capture value |
| cap_hi | output | 8 | High capture value |

## Verification
The split-timer mode is swept over a grid of prescale and match values, with a different match value on each half. The flag counts are taken over a window that is a multiple of every expected period, so a wrong reload point, a wrong prescale divide or crosstalk between the halves each give a different count. A second pattern switches `tick_en` on alternate cycles, which separates counting enabled cycles from counting clock cycles. The wide modes use a match value above 255 and a fixed run of ticks followed by a capture, which exposes carry faults between the halves. Event patterns mix short pulses with one long held-high pulse, which separates edge counting from level counting.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT_TIMERS = 2'd0,
        MODE_TIMER_EVENT  = 2'd1,
        MODE_WIDE_TIMER   = 2'd2,
        MODE_WIDE_EVENT   = 2'd3
    } dct_mode_e;

    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'd0,
        SEL_MATCH_LO = 2'd1,
        SEL_MATCH_HI = 2'd2,
        SEL_NONE     = 2'd3
    } dct_sel_e;

    typedef enum logic {
        EDGE_ARMED = 1'b0,
        EDGE_SPENT = 1'b1
    } dct_edge_e;

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [PRE_W-1:0] limit,
    output logic             step_o
);

    logic [PRE_W-1:0] cnt_q;
    logic             at_limit;

    // A count above the limit (after a lower limit is written) also reloads.
    assign at_limit = (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            step_o <= 1'b0;
        end else begin
            step_o <= tick_en && at_limit;
            if (tick_en) begin
                cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
            end
        end
    end

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> $past(tick_en)); // R2

endmodule

// File: rtl/dct_edge_fsm.sv
module dct_edge_fsm
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pulse_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    dct_edge_e              state_q;
    dct_edge_e              state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EDGE_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_ARMED: if (synced)  state_d = EDGE_SPENT;
            EDGE_SPENT: if (!synced) state_d = EDGE_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            EDGE_ARMED: pulse_o = synced;
            EDGE_SPENT: pulse_o = 1'b0;
        endcase
    end

    AST_ONE_STEP_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R8

endmodule

// File: rtl/dct_count_core.sv
module dct_count_core
    import dct_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dct_mode_e         mode,
    input  logic              pre_step,
    input  logic              evt_step,
    input  logic              cap_lo_trig,
    input  logic              cap_hi_trig,
    input  logic [HALF_W-1:0] match_lo,
    input  logic [HALF_W-1:0] match_hi,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi
);

    localparam int WIDE_W = 2 * HALF_W;

    logic [HALF_W-1:0] cnt_lo_q, cnt_hi_q;
    logic [HALF_W-1:0] lo_next, hi_next;
    logic [WIDE_W-1:0] wide_cnt, wide_match, wide_next;
    logic              lo_adv, hi_adv, wide_adv, wide;

    // Step routing per mode
    always_comb begin
        lo_adv   = 1'b0;
        hi_adv   = 1'b0;
        wide_adv = 1'b0;
        wide     = 1'b0;
        unique case (mode)
            MODE_SPLIT_TIMERS: begin
                lo_adv = pre_step;
                hi_adv = pre_step;
            end
            MODE_TIMER_EVENT: begin
                lo_adv = pre_step;
                hi_adv = evt_step;
            end
            MODE_WIDE_TIMER: begin
                wide     = 1'b1;
                wide_adv = pre_step;
            end
            MODE_WIDE_EVENT: begin
                wide     = 1'b1;
                wide_adv = evt_step;
            end
        endcase
    end

    assign wide_cnt   = {cnt_hi_q, cnt_lo_q};
    assign wide_match = {match_hi, match_lo};

    // A count equal to its match reloads to zero on the next advance.
    always_comb begin
        lo_next   = (cnt_lo_q == match_lo)   ? '0 : cnt_lo_q + 1'b1;
        hi_next   = (cnt_hi_q == match_hi)   ? '0 : cnt_hi_q + 1'b1;
        wide_next = (wide_cnt == wide_match) ? '0 : wide_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo_q <= '0;
            cnt_hi_q <= '0;
            irq_lo   <= 1'b0;
            irq_hi   <= 1'b0;
        end else begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
            if (wide) begin
                if (wide_adv) begin
                    {cnt_hi_q, cnt_lo_q} <= wide_next;
                    irq_hi               <= (wide_next == wide_match);
                end
            end else begin
                if (lo_adv) begin
                    cnt_lo_q <= lo_next;
                    irq_lo   <= (lo_next == match_lo);
                end
                if (hi_adv) begin
                    cnt_hi_q <= hi_next;
                    irq_hi   <= (hi_next == match_hi);
                end
            end
        end
    end

    // Capture copies the pre-advance count and leaves the counters alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_lo <= '0;
            cap_hi <= '0;
        end else if (wide) begin
            if (cap_lo_trig || cap_hi_trig) begin
                {cap_hi, cap_lo} <= wide_cnt;
            end
        end else begin
            if (cap_lo_trig) cap_lo <= cnt_lo_q;
            if (cap_hi_trig) cap_hi <= cnt_hi_q;
        end
    end

    AST_WIDE_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && $past(wide)) |-> !irq_lo); // R7

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_step && !evt_step) |=> $stable(wide_cnt)); // R2

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_lo_trig && !cap_hi_trig) |=> $stable({cap_hi, cap_lo})); // R9

    AST_SPLIT_FLAG_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && $stable(match_lo) && $stable(mode)) |-> (cnt_lo_q == match_lo)); // R3

    AST_WIDE_FLAG_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && wide && $stable(mode) && $stable(wide_match)) |-> (wide_cnt == wide_match)); // R5

endmodule

// File: rtl/dct_capture_timer.sv
module dct_capture_timer
    import dct_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              evt_in,
    input  logic              cap_lo_in,
    input  logic              cap_hi_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [1:0]        mode_sel,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic [HALF_W-1:0] cap_lo,
    output logic [HALF_W-1:0] cap_hi
);

    localparam int N_PINS = 3;

    logic [PRE_W-1:0]  prescale_q;
    logic [HALF_W-1:0] match_lo_q, match_hi_q;
    logic [N_PINS-1:0] raw_pins, pin_steps;
    logic              pre_step;
    dct_sel_e          sel;

    assign sel = dct_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q <= '0;
            match_lo_q <= '1;
            match_hi_q <= '1;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PRESCALE: prescale_q <= wr_data[PRE_W-1:0];
                SEL_MATCH_LO: match_lo_q <= wr_data;
                SEL_MATCH_HI: match_hi_q <= wr_data;
                SEL_NONE:     ;
            endcase
        end
    end

    dct_prescaler #(.PRE_W(PRE_W)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .limit   (prescale_q),
        .step_o  (pre_step)
    );

    // Bit 0: event, bit 1: low capture, bit 2: high capture
    assign raw_pins = {cap_hi_in, cap_lo_in, evt_in};

    for (genvar gi = 0; gi < N_PINS; gi++) begin : g_edge
        dct_edge_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (raw_pins[gi]),
            .pulse_o (pin_steps[gi])
        );
    end

    dct_count_core #(.HALF_W(HALF_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (dct_mode_e'(mode_sel)),
        .pre_step    (pre_step),
        .evt_step    (pin_steps[0]),
        .cap_lo_trig (pin_steps[1]),
        .cap_hi_trig (pin_steps[2]),
        .match_lo    (match_lo_q),
        .match_hi    (match_hi_q),
        .irq_lo      (irq_lo),
        .irq_hi      (irq_hi),
        .cap_lo      (cap_lo),
        .cap_hi      (cap_hi)
    );

    AST_FLAGS_NEED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo || irq_hi) |-> $past(pre_step || pin_steps[0])); // R3

endmodule

// File: tb/dct_capture_timer_bench.sv
module dct_capture_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       evt_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] mode_sel = 2'd0;
    logic       irq_lo, irq_hi;
    logic [7:0] cap_lo, cap_hi;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  n_irq_lo = 0;
    int  n_irq_hi = 0;
    bit  tick_on  = 1'b0;
    bit  tick_alt = 1'b0;

    dct_capture_timer u_dct_capture_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_in(evt_in),
        .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .mode_sel(mode_sel),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .cap_lo(cap_lo), .cap_hi(cap_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (irq_lo) n_irq_lo++;
        if (irq_hi) n_irq_hi++;
    end

    // tick_en source: steady level or alternate cycles
    initial begin
        forever begin
            @(negedge clk);
            tick_en <= tick_alt ? ~tick_en : tick_on;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(posedge clk);
        tick_on  = 1'b0;
        tick_alt = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m;
        evt_in = 1'b0; cap_lo_in = 1'b0; cap_hi_in = 1'b0; wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // which: 0 event, 1 low capture, 2 high capture
    task automatic pulse_pin(input int which, input int high_cycles);
        @(negedge clk);
        if (which == 0) evt_in = 1'b1;
        else if (which == 1) cap_lo_in = 1'b1;
        else cap_hi_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        evt_in = 1'b0; cap_lo_in = 1'b0; cap_hi_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic window(input int w, output int dlo, output int dhi);
        int lo0, hi0;
        @(negedge clk);
        lo0 = n_irq_lo; hi0 = n_irq_hi;
        repeat (w) @(negedge clk);
        dlo = n_irq_lo - lo0;
        dhi = n_irq_hi - hi0;
    endtask

    task automatic run_ticks(input int k);
        @(posedge clk);
        tick_on = 1'b1;
        repeat (k) @(posedge clk);
        tick_on = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int dlo, dhi;

        // R1: reset state and default register values
        do_reset(2'd0);
        check("R1 cap_lo", cap_lo, 0);
        check("R1 cap_hi", cap_hi, 0);
        check("R1 irq_lo", irq_lo, 0);
        check("R1 irq_hi", irq_hi, 0);
        @(posedge clk); tick_on = 1'b1;
        repeat (10) @(negedge clk);
        window(512, dlo, dhi);
        check("R1 default period lo", dlo, 2);
        check("R1 default period hi", dhi, 2);

        // R2 R3 R11: split-timer sweep
        for (int p = 0; p < 3; p++) begin
            for (int mi = 0; mi < 3; mi++) begin
                int pv, mv;
                pv = (p == 2) ? 3 : p;
                mv = (mi == 0) ? 0 : ((mi == 1) ? 2 : 5);
                do_reset(2'd0);
                wr(2'd0, 8'(pv));
                wr(2'd1, 8'(mv));
                wr(2'd2, 8'(mv + 3));
                wr(2'd3, 8'd0); // R11: select 3 stores nothing
                @(posedge clk); tick_on = 1'b1;
                repeat (50) @(negedge clk);
                window(1440, dlo, dhi);
                check("R3 lo flag count", dlo, 1440 / ((pv + 1) * (mv + 1)));
                check("R3 hi flag count", dhi, 1440 / ((pv + 1) * (mv + 4)));
            end
        end

        // R2: tick_en on alternate cycles halves the rate
        do_reset(2'd0);
        wr(2'd0, 8'd1); wr(2'd1, 8'd2); wr(2'd2, 8'd5);
        @(posedge clk); tick_alt = 1'b1;
        repeat (50) @(negedge clk);
        window(1440, dlo, dhi);
        check("R2 gated lo", dlo, 120);
        check("R2 gated hi", dhi, 60);

        // R9: split capture, counter undisturbed
        do_reset(2'd0);
        wr(2'd1, 8'd200); wr(2'd2, 8'd200);
        run_ticks(37);
        pulse_pin(1, 2); repeat (5) @(negedge clk);
        check("R9 cap_lo", cap_lo, 37);
        check("R9 cap_hi untouched", cap_hi, 0);
        pulse_pin(2, 2); repeat (5) @(negedge clk);
        check("R9 cap_hi", cap_hi, 37);
        run_ticks(4);
        pulse_pin(1, 1); repeat (5) @(negedge clk);
        check("R9 count kept after capture", cap_lo, 41);

        // R5 R7: wide timer periods
        do_reset(2'd2);
        wr(2'd1, 8'h04); wr(2'd2, 8'h01);
        @(posedge clk); tick_on = 1'b1;
        repeat (20) @(negedge clk);
        window(1044, dlo, dhi);
        check("R5 wide period 261", dhi, 4);
        check("R7 lo quiet wide timer", dlo, 0);
        do_reset(2'd2);
        wr(2'd0, 8'd2); wr(2'd1, 8'd3); wr(2'd2, 8'd0);
        @(posedge clk); tick_on = 1'b1;
        repeat (20) @(negedge clk);
        window(1200, dlo, dhi);
        check("R5 wide period 12", dhi, 100);

        // R10: wide capture across the carry
        do_reset(2'd2);
        run_ticks(300);
        pulse_pin(2, 2); repeat (5) @(negedge clk);
        check("R10 wide cap low byte", cap_lo, 8'h2C);
        check("R10 wide cap high byte", cap_hi, 8'h01);

        // R4 R8: timer plus event counter
        do_reset(2'd1);
        wr(2'd1, 8'd200); wr(2'd2, 8'd3);
        @(negedge clk);
        dlo = n_irq_lo; dhi = n_irq_hi;
        for (int e = 0; e < 10; e++) pulse_pin(0, 1);
        repeat (6) @(negedge clk);
        check("R4 event flags", n_irq_hi - dhi, 2);
        check("R4 lo idle flags", n_irq_lo - dlo, 0);
        pulse_pin(2, 2); repeat (5) @(negedge clk);
        check("R4 event count", cap_hi, 2);
        pulse_pin(0, 20); repeat (4) @(negedge clk);
        pulse_pin(2, 2); repeat (5) @(negedge clk);
        check("R8 long high counts once", cap_hi, 3);
        run_ticks(5);
        pulse_pin(1, 2); repeat (5) @(negedge clk);
        check("R4 low half timer", cap_lo, 5);
        check("R4 high half unchanged", cap_hi, 3);

        // R6 R7: wide event counter
        do_reset(2'd3);
        wr(2'd1, 8'd2); wr(2'd2, 8'd0);
        @(negedge clk);
        dlo = n_irq_lo; dhi = n_irq_hi;
        for (int e = 0; e < 7; e++) pulse_pin(0, 1);
        repeat (6) @(negedge clk);
        check("R6 wide event flags", n_irq_hi - dhi, 2);
        check("R7 lo quiet wide event", n_irq_lo - dlo, 0);
        pulse_pin(1, 2); repeat (5) @(negedge clk);
        check("R6 wide event count lo", cap_lo, 1);
        check("R6 wide event count hi", cap_hi, 0);

        finish_run();
    end

endmodule